// File: doc/BRIEF.md
# Serial Register Port with CRC-8 Frame Checking

This block is the serial slave front end of a multi-channel converter control chip. A host shifts command words into it over a three-wire synchronous serial link, framed by an active-low select. Every frame carries a read/write flag, a two-bit device address that must match two strap inputs, a five-bit register address and sixteen data bits. With packet checking enabled, an eight-bit CRC follows the command word. Writes reach the register file only after the select returns high, and only if the frame has the right length, a matching CRC and a matching device address.

The serial signals are sampled by the system clock through synchronizers. Reads take two frames. The first frame names the register. The contents are shifted out on the serial output during the next frame, which is normally a no-operation write to address 30. A sticky status register at address 31 records CRC failures and length errors. A CRC failure also pulls the active-low fault output low, and it stays low until the status register is read. When the status-during-write option is enabled, any frame without a pending readback returns the status word on the serial output.

Top module: `dacspi_if`

## Requirements
- R1: A frame is shifted in most significant bit first, one bit on each rising serial clock edge while select is low. The 24-bit command holds the read flag at bit 23 (1 = read, 0 = write), the device address at bits 22:21, the register address at bits 20:16 and the data at bits 15:0. After select rises, a valid write to an address below NUM_REGS stores the data in that register.
- R2: With checking enabled, a frame is 32 bits: the 24-bit command followed by an 8-bit CRC. The CRC uses polynomial x^8+x^2+x+1 (0x07), starts from zero, and runs over the command bits most significant bit first.
- R3: With checking enabled, a frame whose CRC does not match updates no register and starts no read, drives fault_n_o low and sets status bit 0.
- R4: fault_n_o stays low until a valid read of address 31. That read returns the status word (bit 0 = CRC failure, bit 1 = length error, other bits zero) and clears both bits.
- R5: With checking disabled, frames of 24 or 32 bits are accepted and the last 24 bits received are used. With checking enabled, only 32-bit frames are accepted. Any other length is discarded without effect and sets status bit 1.
- R6: A frame whose device address bits differ from dev_addr_i neither writes a register nor requests a read.
- R7: After a valid read request, the next frame outputs 8 zero bits, then the 16 register bits, then 8 trailer bits. The serial output advances on each falling serial clock edge. A host sampling on rising edges therefore sees 8 leading don't-care bits when the clock idles low and 7 when it idles high. Addresses with no register read as zero.
- R8: The trailer bits are the CRC (as in R2) of the 24-bit output word {8'h00, data} when checking is enabled, and zero otherwise.
- R9: With stat_wr_en_i high, a frame that follows no read request outputs the status word in the same layout as R7. With stat_wr_en_i low, such a frame outputs all zeros.
- R10: sdo_oe_o is low whenever the select input has been high for more than the synchronizer delay, and fault_n_o is high after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Active-low frame select |
| mosi_i | input | 1 | Serial data into the block |
| dev_addr_i | input | 2 | Device address straps |
| crc_en_i | input | 1 | Enables 32-bit frames with CRC checking |
| stat_wr_en_i | input | 1 | Returns the status word during frames without a readback |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o (the pad is tri-stated when low) |
| fault_n_o | output | 1 | Active-low CRC fault flag |

## Verification
The assertions assume that the serial clock holds each level, and that select keeps each new level, for several system clocks longer than the synchronizer depth. They also assume that select stays high for at least four system clocks between frames, so that one commit ends before the next frame starts, and that the mode inputs change only while select is high. The stimulus meets these conditions by holding every serial clock phase for six system clocks and leaving at least fourteen clocks between frames. It sets the mode inputs only between frames, and it changes the data line only while the serial clock is low or just before a rising edge.

// File: rtl/dacspi_pkg.sv
package dacspi_pkg;

  localparam int unsigned CMD_W   = 24;
  localparam int unsigned CRC_W   = 8;
  localparam int unsigned FRAME_W = CMD_W + CRC_W;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned RADDR_W = 5;
  localparam int unsigned LEAD_W  = CMD_W - DATA_W;

  localparam logic [RADDR_W-1:0] STAT_ADDR = 5'd31;
  localparam logic [CRC_W-1:0]   CRC_POLY  = 8'h07;

  typedef struct packed {
    logic               rd;
    logic [1:0]         dev;
    logic [RADDR_W-1:0] addr;
    logic [DATA_W-1:0]  data;
  } cmd_t;

  function automatic logic [CRC_W-1:0] crc8_cmd(input logic [CMD_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = '0;
    for (int i = CMD_W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/dacspi_sync.sv
module dacspi_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '1;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '1;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/dacspi_rx.sv
module dacspi_rx #(
  parameter int unsigned FW = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   bit_stb,
  input  logic                   bit_in,
  output logic [FW-1:0]          shreg,
  output logic [$clog2(FW+2)-1:0] count
);

  localparam int unsigned CW = $clog2(FW + 2);
  localparam logic [CW-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      count <= '0;
    end else if (start) begin
      shreg <= '0;
      count <= '0;
    end else if (bit_stb) begin
      shreg <= {shreg[FW-2:0], bit_in};
      if (count != CMAX) count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/dacspi_tx.sv
module dacspi_tx #(
  parameter int unsigned FW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [FW-1:0] word,
  input  logic          shift,
  input  logic          stop,
  output logic          sdo,
  output logic          oe
);

  logic [FW-1:0] osr;

  always_ff @(posedge clk) begin
    if (rst) begin
      osr <= '0;
      sdo <= 1'b0;
      oe  <= 1'b0;
    end else if (load) begin
      osr <= word;
      sdo <= word[FW-1];
      oe  <= 1'b1;
    end else if (stop) begin
      sdo <= 1'b0;
      oe  <= 1'b0;
    end else if (shift) begin
      osr <= {osr[FW-2:0], 1'b0};
      sdo <= osr[FW-2];
    end
  end

endmodule

// File: rtl/dacspi_regs.sv
module dacspi_regs #(
  parameter int unsigned NUM = 8,
  parameter int unsigned DW  = 16,
  localparam int unsigned AW = (NUM > 1) ? $clog2(NUM) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [NUM];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/dacspi_if.sv
module dacspi_if
  import dacspi_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk_i,
  input  logic       cs_n_i,
  input  logic       mosi_i,
  input  logic [1:0] dev_addr_i,
  input  logic       crc_en_i,
  input  logic       stat_wr_en_i,
  output logic       sdo_o,
  output logic       sdo_oe_o,
  output logic       fault_n_o
);

  localparam int unsigned AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int unsigned CW = $clog2(FRAME_W + 2);
  localparam logic [CW-1:0] LEN_SHORT = CW'(CMD_W);
  localparam logic [CW-1:0] LEN_LONG  = CW'(FRAME_W);
  localparam logic [RADDR_W-1:0] REG_LIMIT = RADDR_W'(NUM_REGS);

  // input synchronization and edge detection
  logic [2:0] pins_s;
  logic       sclk_s, cs_act, mosi_s;
  logic       sclk_d, cs_act_d;
  logic       cs_fall_ev, cs_rise_ev, sclk_rise_ev, sclk_fall_ev;

  dacspi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclk_i, cs_n_i, mosi_i}),
    .q   (pins_s)
  );

  assign sclk_s = pins_s[2];
  assign cs_act = ~pins_s[1];
  assign mosi_s = pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      cs_act_d <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      cs_act_d <= cs_act;
    end
  end

  assign cs_fall_ev   = cs_act & ~cs_act_d;
  assign cs_rise_ev   = ~cs_act & cs_act_d;
  assign sclk_rise_ev = cs_act & sclk_s & ~sclk_d;
  assign sclk_fall_ev = cs_act & ~sclk_s & sclk_d;

  // receive path
  logic [FRAME_W-1:0] rx_sh;
  logic [CW-1:0]      rx_cnt;

  dacspi_rx #(.FW(FRAME_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .start   (cs_fall_ev),
    .bit_stb (sclk_rise_ev),
    .bit_in  (mosi_s),
    .shreg   (rx_sh),
    .count   (rx_cnt)
  );

  // frame decode (stage 0, valid in the cycle of cs_rise_ev)
  cmd_t d_cmd;
  logic d_len_ok, d_crc_ok, d_addr_ok;

  always_comb begin
    if (crc_en_i) begin
      d_cmd    = cmd_t'(rx_sh[FRAME_W-1:CRC_W]);
      d_len_ok = (rx_cnt == LEN_LONG);
      d_crc_ok = (crc8_cmd(rx_sh[FRAME_W-1:CRC_W]) == rx_sh[CRC_W-1:0]);
    end else begin
      d_cmd    = cmd_t'(rx_sh[CMD_W-1:0]);
      d_len_ok = (rx_cnt == LEN_SHORT) || (rx_cnt == LEN_LONG);
      d_crc_ok = 1'b1;
    end
    d_addr_ok = (d_cmd.dev == dev_addr_i);
  end

  // commit stage registers
  logic p1, q_len_ok, q_crc_ok, q_addr_ok;
  cmd_t q_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      p1        <= 1'b0;
      q_len_ok  <= 1'b0;
      q_crc_ok  <= 1'b0;
      q_addr_ok <= 1'b0;
      q_cmd     <= '0;
    end else begin
      p1 <= cs_rise_ev;
      if (cs_rise_ev) begin
        q_len_ok  <= d_len_ok;
        q_crc_ok  <= d_crc_ok;
        q_addr_ok <= d_addr_ok;
        q_cmd     <= d_cmd;
      end
    end
  end

  // register file
  logic [DATA_W-1:0] reg_q;
  logic              q_in_range;
  logic              frame_ok, crc_bad, len_bad, wr_en, rd_req, stat_clr;

  assign q_in_range = (q_cmd.addr < REG_LIMIT);
  assign frame_ok   = q_len_ok & q_crc_ok & q_addr_ok;
  assign len_bad    = p1 & ~q_len_ok;
  assign crc_bad    = p1 & q_len_ok & ~q_crc_ok;
  assign wr_en      = p1 & frame_ok & ~q_cmd.rd & q_in_range;
  assign rd_req     = p1 & frame_ok & q_cmd.rd;
  assign stat_clr   = rd_req & (q_cmd.addr == STAT_ADDR);

  dacspi_regs #(.NUM(NUM_REGS), .DW(DATA_W)) u_regs (
    .clk   (clk),
    .we    (wr_en),
    .waddr (q_cmd.addr[AW-1:0]),
    .wdata (q_cmd.data),
    .raddr (d_cmd.addr[AW-1:0]),
    .rdata (reg_q)
  );

  // sticky status and readback holding register
  logic              len_flag;
  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] rd_data;
  logic              rd_pend;

  assign status_w = {{(DATA_W-2){1'b0}}, len_flag, ~fault_n_o};

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_n_o <= 1'b1;
      len_flag  <= 1'b0;
      rd_data   <= '0;
      rd_pend   <= 1'b0;
    end else begin
      if (stat_clr) begin
        fault_n_o <= 1'b1;
        len_flag  <= 1'b0;
      end else begin
        if (crc_bad) fault_n_o <= 1'b0;
        if (len_bad) len_flag  <= 1'b1;
      end
      if (rd_req) begin
        rd_pend <= 1'b1;
        if (stat_clr)        rd_data <= status_w;
        else if (q_in_range) rd_data <= reg_q;
        else                 rd_data <= '0;
      end else if (cs_fall_ev) begin
        rd_pend <= 1'b0;
      end
    end
  end

  // transmit word selection
  logic [DATA_W-1:0]  tx_data;
  logic               tx_any;
  logic [CRC_W-1:0]   tx_crc;
  logic [FRAME_W-1:0] tx_word;

  always_comb begin
    tx_any  = rd_pend | stat_wr_en_i;
    tx_data = rd_pend ? rd_data : status_w;
    tx_crc  = crc_en_i ? crc8_cmd({{LEAD_W{1'b0}}, tx_data}) : '0;
    tx_word = tx_any ? {{LEAD_W{1'b0}}, tx_data, tx_crc} : '0;
  end

  dacspi_tx #(.FW(FRAME_W)) u_tx (
    .clk   (clk),
    .rst   (rst),
    .load  (cs_fall_ev),
    .word  (tx_word),
    .shift (sclk_fall_ev),
    .stop  (cs_rise_ev),
    .sdo   (sdo_o),
    .oe    (sdo_oe_o)
  );

endmodule

// File: rtl/dacspi_if_chk.sv
module dacspi_if_chk (
  input logic clk,
  input logic rst,
  input logic cs_act,
  input logic sclk_fall_ev,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic fault_n_o,
  input logic stat_clr,
  input logic crc_bad,
  input logic len_bad,
  input logic wr_en,
  input logic rd_req
);

  AST_SDO_IDLE_OFF: assert property (@(posedge clk) disable iff (rst)
    (!cs_act && $past(!cs_act)) |-> !sdo_oe_o);  // R10

  AST_FAULT_SET: assert property (@(posedge clk) disable iff (rst)
    crc_bad |=> !fault_n_o);  // R3

  AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_n_o) |-> $past(stat_clr));  // R4

  AST_BAD_LEN_REJECT: assert property (@(posedge clk) disable iff (rst)
    len_bad |-> (!wr_en && !rd_req));  // R5

  AST_SDO_SHIFT_ONLY: assert property (@(posedge clk) disable iff (rst)
    (cs_act && $past(cs_act) && $past(cs_act, 2) && !$past(sclk_fall_ev))
      |-> $stable(sdo_o));  // R7

endmodule

bind dacspi_if dacspi_if_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .cs_act       (cs_act),
  .sclk_fall_ev (sclk_fall_ev),
  .sdo_o        (sdo_o),
  .sdo_oe_o     (sdo_oe_o),
  .fault_n_o    (fault_n_o),
  .stat_clr     (stat_clr),
  .crc_bad      (crc_bad),
  .len_bad      (len_bad),
  .wr_en        (wr_en),
  .rd_req       (rd_req)
);

// File: tb/dacspi_if_test.sv
module dacspi_if_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk = 1'b0;
  logic       cs_n = 1'b1;
  logic       mosi = 1'b0;
  logic [1:0] dev_addr = 2'b10;
  logic       crc_on = 1'b0;
  logic       stat_wr = 1'b0;
  logic       sdo, sdo_oe, fault_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int idle_cnt = 0;

  always #5 clk = ~clk;

  dacspi_if uut (
    .clk          (clk),
    .rst          (rst),
    .sclk_i       (sclk),
    .cs_n_i       (cs_n),
    .mosi_i       (mosi),
    .dev_addr_i   (dev_addr),
    .crc_en_i     (crc_on),
    .stat_wr_en_i (stat_wr),
    .sdo_o        (sdo),
    .sdo_oe_o     (sdo_oe),
    .fault_n_o    (fault_n)
  );

  // behavioural reference state
  logic [15:0] m_regs [32];
  bit          m_fault = 0;
  bit          m_len = 0;
  bit          m_pend = 0;
  logic [15:0] m_rdat = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bcrc(input logic [23:0] d);
    logic [31:0] r;
    r = {d, 8'h00};
    for (int i = 31; i >= 8; i--)
      if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
    return r[7:0];
  endfunction

  function automatic logic [15:0] m_status();
    return {14'd0, m_len, m_fault};
  endfunction

  function automatic logic [31:0] model_out();
    logic [15:0] d;
    if (!m_pend && !stat_wr) return 32'd0;
    d = m_pend ? m_rdat : m_status();
    return {8'h00, d, crc_on ? bcrc({8'h00, d}) : 8'h00};
  endfunction

  task automatic model_commit(input int nbits, input logic [31:0] w);
    logic [23:0] c;
    bit len_ok, crc_ok;
    if (crc_on) begin
      len_ok = (nbits == 32);
      c = w[31:8];
      crc_ok = (bcrc(w[31:8]) == w[7:0]);
    end else begin
      len_ok = (nbits == 24) || (nbits == 32);
      c = w[23:0];
      crc_ok = 1;
    end
    if (!len_ok) m_len = 1;
    else if (!crc_ok) m_fault = 1;
    else if (c[22:21] == dev_addr) begin
      if (c[23]) begin
        m_pend = 1;
        if (c[20:16] == 5'd31) begin
          m_rdat = m_status();
          m_fault = 0;
          m_len = 0;
        end else m_rdat = (c[20:16] < 8) ? m_regs[c[20:16]] : 16'h0;
      end else if (c[20:16] < 8) m_regs[c[20:16]] = c[15:0];
    end
  endtask

  task automatic xfer(input int nbits, input logic [31:0] w, input bit hi, input string tag);
    logic [31:0] exp, cap, mask;
    exp = model_out();
    m_pend = 0;
    cap = '0;
    sclk = hi;
    repeat (6) @(negedge clk);
    cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      if (hi) sclk = 1'b0;
      mosi = w[nbits-1-k];
      repeat (6) @(negedge clk);
      cap[31-k] = sdo;
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      if (!hi) sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (14) @(negedge clk);
    model_commit(nbits, w);
    mask = 32'hFFFF_FFFF << (32 - nbits);
    if (hi) exp = exp << 1;
    check({tag, " sdo"}, cap & mask, exp & mask);
    check({tag, " fault_n"}, {31'd0, fault_n}, {31'd0, ~m_fault});
  endtask

  function automatic logic [23:0] cmd(input bit rd, input logic [1:0] dv,
                                      input logic [4:0] a, input logic [15:0] d);
    return {rd, dv, a, d};
  endfunction

  task automatic send(input bit rd, input logic [1:0] dv, input logic [4:0] a,
                      input logic [15:0] d, input bit hi, input string tag);
    logic [23:0] c;
    c = cmd(rd, dv, a, d);
    if (crc_on) xfer(32, {c, bcrc(c)}, hi, tag);
    else        xfer(24, {8'h00, c}, hi, tag);
  endtask

  // sdo enable must be off while select is idle
  always @(negedge clk) begin
    if (!rst && cs_n) begin
      if (idle_cnt < 1000) idle_cnt++;
      if (idle_cnt >= 4)
        check("R10 sdo_oe idle", {31'd0, sdo_oe}, 32'd0);
    end else idle_cnt = 0;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) m_regs[i] = 16'h0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 reset fault_n", {31'd0, fault_n}, 32'd1);
    check("R10 reset sdo_oe", {31'd0, sdo_oe}, 32'd0);

    // clear all registers so that readback is defined
    for (int i = 0; i < 8; i++) send(0, 2'b10, 5'(i), 16'h0, 0, "R1 init");

    send(0, 2'b10, 5'd3, 16'hA5C3, 0, "R1 write");
    send(1, 2'b10, 5'd3, 16'h0, 0, "R1 read req");
    send(0, 2'b10, 5'd30, 16'h0, 0, "R7 readback idle low");
    send(1, 2'b10, 5'd3, 16'h0, 1, "R7 read req idle high");
    send(0, 2'b10, 5'd30, 16'h0, 1, "R7 readback idle high");

    send(0, 2'b01, 5'd3, 16'h1111, 0, "R6 wrong device write");
    send(1, 2'b11, 5'd3, 16'h0, 0, "R6 wrong device read");
    send(0, 2'b10, 5'd30, 16'h0, 0, "R6 no readback");
    send(1, 2'b10, 5'd3, 16'h0, 0, "R6 read req");
    send(0, 2'b10, 5'd30, 16'h0, 0, "R6 reg unchanged");

    xfer(23, {9'd0, cmd(0, 2'b10, 5'd3, 16'h7777)} >> 1, 0, "R5 short frame");
    xfer(32, {8'hC3, cmd(0, 2'b10, 5'd4, 16'h0F0F)}, 0, "R5 long frame crc off");
    send(1, 2'b10, 5'd4, 16'h0, 0, "R5 read req");
    send(0, 2'b10, 5'd30, 16'h0, 0, "R5 long frame stored");
    send(1, 2'b10, 5'd31, 16'h0, 0, "R4 status read req");
    send(0, 2'b10, 5'd30, 16'h0, 0, "R5 status length bit");

    crc_on = 1'b1;
    send(0, 2'b10, 5'd5, 16'hBEEF, 0, "R2 crc write");
    send(1, 2'b10, 5'd5, 16'h0, 0, "R2 crc read req");
    send(0, 2'b10, 5'd30, 16'h0, 0, "R8 readback crc");
    send(1, 2'b10, 5'd6, 16'h0, 1, "R8 read unmapped-free reg");
    send(0, 2'b10, 5'd30, 16'h0, 1, "R8 readback crc idle high");

    xfer(32, {cmd(0, 2'b10, 5'd5, 16'h0000), 8'h5A ^ bcrc(cmd(0, 2'b10, 5'd5, 16'h0000))},
         0, "R3 bad crc write");
    check("R3 fault low", {31'd0, fault_n}, 32'd0);
    xfer(24, {8'h00, cmd(0, 2'b10, 5'd5, 16'h1234)}, 0, "R5 24-bit in crc mode");
    send(1, 2'b10, 5'd5, 16'h0, 0, "R3 read req");
    send(0, 2'b10, 5'd30, 16'h0, 0, "R3 reg unchanged");
    check("R4 fault still low", {31'd0, fault_n}, 32'd0);
    send(1, 2'b10, 5'd31, 16'h0, 0, "R4 status read clears");
    check("R4 fault released", {31'd0, fault_n}, 32'd1);
    send(0, 2'b10, 5'd30, 16'h0, 0, "R4 status content");
    send(1, 2'b10, 5'd20, 16'h0, 0, "R7 unmapped read req");
    send(0, 2'b10, 5'd30, 16'h0, 0, "R7 unmapped reads zero");

    crc_on = 1'b0;
    send(0, 2'b10, 5'd7, 16'h00FF, 0, "R9 write without status mode");
    xfer(20, 32'h0, 0, "R9 short frame sets length bit");
    stat_wr = 1'b1;
    send(0, 2'b10, 5'd7, 16'h3C3C, 0, "R9 status during write");
    send(0, 2'b10, 5'd2, 16'h0001, 1, "R9 status during write idle high");
    stat_wr = 1'b0;
    send(1, 2'b10, 5'd7, 16'h0, 0, "R9 read req");
    send(0, 2'b10, 5'd30, 16'h0, 0, "R9 write landed");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule